// File: doc/BRIEF.md
# Per-Task Memory Bank Register File

This block keeps a small bank selector for each of the sixteen microcode tasks of a microprogrammed processor. It widens the 16-bit address produced by the ALU into an 18-bit physical address whenever the running task loads its memory address register. Each selector is a 4-bit nibble holding two 2-bit bank numbers. The upper pair is the normal bank. The lower pair is the extended bank. The extended bank is used only when a microinstruction strobes load-MAR and load-MD together. That combination is an extended-address load, and it also cancels the data write that load-MD would otherwise start.

Software reaches the selectors through a 16-word memory-mapped window at octal 0177740 to 0177757 (hex FFE0 to FFEF). The low four address bits pick the task entry.
- A write keeps only the low nibble of the data word.
- A read returns the nibble with all upper twelve bits set.
- An access outside the window writes nothing and reads as zero.

The block has no sequencing of its own. The bank-kind selection is a two-value enumeration, NORMAL or EXTENDED. It is chosen per cycle: the choice moves from NORMAL to EXTENDED when load-MD accompanies load-MAR, and falls back to NORMAL otherwise.

Top module: `bank_xlate`

## Requirements
- R1: After reset every entry is zero, so a window read at any of the 16 addresses returns 16'hFFF0, and `mem_addr` is zero.
- R2: A write with `mmio_we` high to address FFE0+t stores `mmio_wdata[3:0]` into entry t at the clock edge. Data bits 15..4 are discarded.
- R3: A read in the window returns {12'hFFF, entry} combinationally. An address outside FFE0..FFEF returns 16'h0000.
- R4: A write outside the window changes no entry.
- R5: When `ld_mar` is high and `ld_md` is low, `mem_addr` becomes {entry[task_id][3:2], alu_res} at the next edge.
- R6: When `ld_mar` and `ld_md` are both high, `mem_addr` becomes {entry[task_id][1:0], alu_res} at the next edge.
- R7: `wr_suppress` is high exactly while `ld_mar` and `ld_md` are both high. `ld_md` alone leaves it low.
- R8: `mem_addr` holds its value in any cycle without `ld_mar`.
- R9: A window write and a load-MAR in the same cycle: the load uses the entry's old value, and the new value serves later loads.
- R10: The entry used for a load is the one indexed by `task_id`. Other tasks' entries have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_id | input | 4 | Number of the running task |
| ld_mar | input | 1 | Load-MAR function strobe |
| ld_md | input | 1 | Load-MD function strobe |
| alu_res | input | 16 | ALU result, low part of the address |
| mmio_addr | input | 16 | Memory-mapped access address |
| mmio_we | input | 1 | Memory-mapped write strobe |
| mmio_wdata | input | 16 | Memory-mapped write data |
| mmio_rdata | output | 16 | Memory-mapped read data |
| mem_addr | output | 18 | Registered physical memory address |
| wr_suppress | output | 1 | Cancels the data write of an extended-address load |

## Verification
Two functions can fall in the same cycle: a window write to an entry and a load-MAR by the task that owns that entry. The bench provokes this by writing a new nibble to entry 3 while task 3 loads MAR. It then expects the old normal bank in `mem_addr`, and the new bank on the following load. A second overlap pairs load-MD with load-MAR. The bench judges it by the extended bank appearing in the address and by `wr_suppress` rising during that cycle only.

// File: rtl/bank_pkg.sv
`timescale 1ns/1ps
package bank_pkg;
    localparam int BANK_W = 2;
    localparam int NIB_W  = 2 * BANK_W;

    // Nibble layout: normal bank in the upper pair, extended bank in the lower pair.
    typedef struct packed {
        logic [BANK_W-1:0] norm_bank;
        logic [BANK_W-1:0] ext_bank;
    } bank_sel_t;

    typedef enum logic [0:0] {
        SEL_NORMAL   = 1'b0,
        SEL_EXTENDED = 1'b1
    } bank_kind_e;
endpackage

// File: rtl/bank_store.sv
`timescale 1ns/1ps
module bank_store
    import bank_pkg::*;
#(
    parameter int          TASKS    = 16,
    parameter int          WORD_W   = 16,
    parameter logic [15:0] WIN_BASE = 16'hFFE0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WORD_W-1:0]        mmio_addr,
    input  logic                     mmio_we,
    input  logic [WORD_W-1:0]        mmio_wdata,
    output logic [WORD_W-1:0]        mmio_rdata,
    input  logic [$clog2(TASKS)-1:0] rd_task,
    output bank_sel_t                rd_sel
);
    localparam int              TASK_W = $clog2(TASKS);
    localparam logic [WORD_W-1:0] BASE = WORD_W'(WIN_BASE);

    bank_sel_t [TASKS-1:0] ent_q;
    logic [TASKS-1:0]      we_vec;
    logic                  win_hit;
    logic [TASK_W-1:0]     win_idx;

    assign win_hit = (mmio_addr[WORD_W-1:TASK_W] == BASE[WORD_W-1:TASK_W]);
    assign win_idx = mmio_addr[TASK_W-1:0];

    // One write enable per task entry.
    for (genvar g = 0; g < TASKS; g++) begin : g_we
        assign we_vec[g] = mmio_we && win_hit && (win_idx == TASK_W'(g));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else begin
            for (int i = 0; i < TASKS; i++) begin
                if (we_vec[i]) ent_q[i] <= bank_sel_t'(mmio_wdata[NIB_W-1:0]);
            end
        end
    end

    always_comb begin
        if (win_hit) mmio_rdata = {{(WORD_W-NIB_W){1'b1}}, ent_q[win_idx]};
        else         mmio_rdata = '0;
    end

    // Combinational view of the running task's entry (old value on a same-cycle write).
    assign rd_sel = ent_q[rd_task];

    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mmio_we && win_hit) |=> ent_q[$past(win_idx)] == bank_sel_t'($past(mmio_wdata[NIB_W-1:0])));

    assert_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mmio_we || !win_hit) |=> $stable(ent_q));
endmodule

// File: rtl/mar_extend.sv
`timescale 1ns/1ps
module mar_extend
    import bank_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_mar,
    input  logic                     ld_md,
    input  logic [WORD_W-1:0]        alu_res,
    input  bank_sel_t                bank,
    output logic [BANK_W+WORD_W-1:0] mem_addr,
    output logic                     wr_suppress
);
    bank_kind_e        kind;
    logic [BANK_W-1:0] pick;

    always_comb begin
        unique case (ld_md)
            1'b1:    kind = SEL_EXTENDED;
            default: kind = SEL_NORMAL;
        endcase
    end

    always_comb begin
        unique case (kind)
            SEL_EXTENDED: pick = bank.ext_bank;
            default:      pick = bank.norm_bank;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      mem_addr <= '0;
        else if (ld_mar) mem_addr <= {pick, alu_res};
    end

    assign wr_suppress = ld_mar && (kind == SEL_EXTENDED);

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_mar |=> $stable(mem_addr));

    assert_norm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mar && !ld_md) |=> mem_addr == {$past(bank.norm_bank), $past(alu_res)});

    assert_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mar && ld_md) |=> mem_addr == {$past(bank.ext_bank), $past(alu_res)});

    assert_supp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_suppress |-> (ld_mar && ld_md));
endmodule

// File: rtl/bank_xlate.sv
`timescale 1ns/1ps
module bank_xlate
    import bank_pkg::*;
#(
    parameter int          TASKS    = 16,
    parameter int          WORD_W   = 16,
    parameter logic [15:0] WIN_BASE = 16'hFFE0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(TASKS)-1:0]   task_id,
    input  logic                       ld_mar,
    input  logic                       ld_md,
    input  logic [WORD_W-1:0]          alu_res,
    input  logic [WORD_W-1:0]          mmio_addr,
    input  logic                       mmio_we,
    input  logic [WORD_W-1:0]          mmio_wdata,
    output logic [WORD_W-1:0]          mmio_rdata,
    output logic [BANK_W+WORD_W-1:0]   mem_addr,
    output logic                       wr_suppress
);
    bank_sel_t cur_sel;

    bank_store #(.TASKS(TASKS), .WORD_W(WORD_W), .WIN_BASE(WIN_BASE)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .mmio_addr  (mmio_addr),
        .mmio_we    (mmio_we),
        .mmio_wdata (mmio_wdata),
        .mmio_rdata (mmio_rdata),
        .rd_task    (task_id),
        .rd_sel     (cur_sel)
    );

    mar_extend #(.WORD_W(WORD_W)) u_mar (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_mar      (ld_mar),
        .ld_md       (ld_md),
        .alu_res     (alu_res),
        .bank        (cur_sel),
        .mem_addr    (mem_addr),
        .wr_suppress (wr_suppress)
    );
endmodule

// File: tb/test_bank_xlate.sv
`timescale 1ns/1ps
module test_bank_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  task_id = '0;
    logic        ld_mar = 1'b0, ld_md = 1'b0, mmio_we = 1'b0;
    logic [15:0] alu_res = '0, mmio_addr = '0, mmio_wdata = '0;
    logic [15:0] mmio_rdata;
    logic [17:0] mem_addr;
    logic        wr_suppress;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bank_xlate i_bank_xlate (
        .clk(clk), .rst_n(rst_n), .task_id(task_id), .ld_mar(ld_mar), .ld_md(ld_md),
        .alu_res(alu_res), .mmio_addr(mmio_addr), .mmio_we(mmio_we),
        .mmio_wdata(mmio_wdata), .mmio_rdata(mmio_rdata), .mem_addr(mem_addr),
        .wr_suppress(wr_suppress)
    );

    // Vector: [38:35] task, [34] extended, [33:18] alu, [17:0] expected address.
    // Entry t is preloaded with nibble t (normal = t[3:2], extended = t[1:0]).
    localparam logic [38:0] VEC [8] = '{
        {4'd5,  1'b0, 16'h1234, 18'h11234},
        {4'd5,  1'b1, 16'hABCD, 18'h1ABCD},
        {4'd14, 1'b0, 16'h0000, 18'h30000},
        {4'd14, 1'b1, 16'hFFFF, 18'h2FFFF},
        {4'd0,  1'b0, 16'h8001, 18'h08001},
        {4'd15, 1'b1, 16'h5555, 18'h35555},
        {4'd9,  1'b0, 16'h0F0F, 18'h20F0F},
        {4'd9,  1'b1, 16'h7777, 18'h17777}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mmio_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        mmio_addr = a; mmio_wdata = d; mmio_we = 1'b1;
        @(negedge clk);
        mmio_we = 1'b0;
    endtask

    task automatic mmio_read(input string req, input logic [15:0] a, input logic [15:0] exp);
        mmio_addr = a;
        #1;
        chk(req, 32'(mmio_rdata), 32'(exp));
    endtask

    task automatic mar_load(input logic [3:0] t, input logic ext, input logic [15:0] a);
        @(negedge clk);
        task_id = t; alu_res = a; ld_mar = 1'b1; ld_md = ext;
        #1;
        chk("R7 suppress during load", 32'(wr_suppress), 32'(ext));
        @(negedge clk);
        ld_mar = 1'b0; ld_md = 1'b0;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mem_addr after reset", 32'(mem_addr), 32'h0);
        for (int t = 0; t < 16; t++) mmio_read("R1 reset entry", 16'hFFE0 + 16'(t), 16'hFFF0);

        // R2 preload with junk in upper bits, read back
        for (int t = 0; t < 16; t++) mmio_write(16'hFFE0 + 16'(t), 16'hABC0 | 16'(t));
        for (int t = 0; t < 16; t++) mmio_read("R2 stored nibble", 16'hFFE0 + 16'(t), 16'hFFF0 | 16'(t));

        // R3 outside window reads zero
        mmio_read("R3 read above window", 16'hFFF0, 16'h0000);
        mmio_read("R3 read below window", 16'hFFDF, 16'h0000);

        // R4 write outside window ignored
        mmio_write(16'hFFF0, 16'h000F);
        mmio_write(16'h7FE3, 16'h000F);
        mmio_read("R4 entry0 untouched", 16'hFFE0, 16'hFFF0);
        mmio_read("R4 entry3 untouched", 16'hFFE3, 16'hFFF3);

        // R5 R6 R10 vector table
        foreach (VEC[i]) begin
            mar_load(VEC[i][38:35], VEC[i][34], VEC[i][33:18]);
            chk(VEC[i][34] ? "R6 extended load" : "R5 normal load R10",
                32'(mem_addr), 32'(VEC[i][17:0]));
        end

        // R7 load-MD alone: no suppress; R8 address holds
        @(negedge clk);
        ld_md = 1'b1; alu_res = 16'h1111; task_id = 4'd3;
        #1;
        chk("R7 md alone", 32'(wr_suppress), 32'h0);
        @(negedge clk);
        ld_md = 1'b0;
        chk("R8 hold without load", 32'(mem_addr), 32'h17777);

        // R9 same-cycle write and load: old nibble 3 (normal 00), new C (normal 11)
        @(negedge clk);
        mmio_addr = 16'hFFE3; mmio_wdata = 16'h000C; mmio_we = 1'b1;
        task_id = 4'd3; alu_res = 16'h0001; ld_mar = 1'b1; ld_md = 1'b0;
        @(negedge clk);
        mmio_we = 1'b0; ld_mar = 1'b0;
        chk("R9 load sees old bank", 32'(mem_addr), 32'h00001);
        mar_load(4'd3, 1'b0, 16'h0001);
        chk("R9 next load sees new bank", 32'(mem_addr), 32'h30001);

        // R1 reset again clears entries and address
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 mem_addr after second reset", 32'(mem_addr), 32'h0);
        mmio_read("R1 entry cleared", 16'hFFEF, 16'hFFF0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule